// File: doc/BRIEF.md
# Condition-Field Masked LUT Logic Unit

This unit updates a 32-bit condition register that is divided into eight 4-bit fields. It offers two operations. The ternary operation computes all four bits of a target field as an arbitrary 3-input Boolean function. The inputs are the matching bits of three selected source fields, and an 8-bit immediate truth table defines the function. The binary operation computes a 2-input Boolean function of two source fields. Its 4-bit truth table is not an immediate. It is read at run time from a third field of the same register.

Each operation writes only the target-field bits enabled by a 4-bit write mask. Every other bit of the register passes through unchanged. The caller presents the current register, the selectors, the truth-table immediate, the mask and the operation select, together with a valid strobe. The updated register appears on the next clock edge with an output valid flag.

Top module: `cfl_unit`

## Requirements
- R1: Field n (0..7) occupies `cr_in[31-4n : 28-4n]`. Field bit 0 (the most significant bit of the field) is `cr_in[31-4n]`, and field bit 3 is `cr_in[28-4n]`.
- R2: When `op_sel`=0 (ternary), field bit k of the result equals `lut_imm[idx]`. Here idx = 4*A + 2*B + C, where A, B and C are bit k of the fields picked by `src_a_sel`, `src_b_sel` and `src_c_sel`.
- R3: When `op_sel`=1 (binary), field bit k of the result equals bit idx of the 4-bit value of the field picked by `src_c_sel`. Here idx = 2*A + B, and field bit 3 of that field has weight 1.
- R4: `wr_mask[3-k]` enables field bit k of the target field. A target bit whose mask bit is clear keeps its `cr_in` value. A mask of zero returns `cr_in` unchanged.
- R5: Every bit outside the field picked by `tgt_sel` equals the corresponding bit of `cr_in`.
- R6: All sources are taken from `cr_in` before the write. A target that is also a source uses its old contents.
- R7: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and `cr_out` carries that result. Without `in_valid`, `cr_out` holds its last value.
- R8: While `rst` is sampled high, `out_valid` is 0 and `cr_out` is all zeros on the following cycle.
- R9: In binary mode `lut_imm` has no effect on `cr_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 1 | 0 = ternary immediate LUT, 1 = binary field LUT |
| cr_in | input | 32 | Current condition register |
| tgt_sel | input | 3 | Target field |
| src_a_sel | input | 3 | First source field (index MSB) |
| src_b_sel | input | 3 | Second source field |
| src_c_sel | input | 3 | Third source field (ternary) or LUT field (binary) |
| lut_imm | input | 8 | Ternary truth table |
| wr_mask | input | 4 | Per-bit write enable, bit 3 for field bit 0 |
| out_valid | output | 1 | Result valid |
| cr_out | output | 32 | Updated condition register |

## Verification
The assertions assume that `cr_in`, the selectors and the mask hold stable, known values during any cycle in which `in_valid` is high. They also assume that reset is applied synchronously for at least one edge. The bench meets both assumptions by changing inputs only on the falling clock edge and by holding reset across several rising edges. It pulses `in_valid` for one cycle per operation and drops it before the next one. The result and the hold behaviour can therefore both be observed, and results from one operation never mix with the next.

// File: rtl/cfl_pkg.sv
package cfl_pkg;

    localparam int FIELD_W    = 4;
    localparam int NUM_FIELDS = 8;
    localparam int CR_W       = FIELD_W * NUM_FIELDS;
    localparam int SEL_W      = $clog2(NUM_FIELDS);
    localparam int TLUT_W     = 1 << 3;
    localparam int BLUT_W     = 1 << 2;

    typedef logic [FIELD_W-1:0] field_t;
    typedef logic [SEL_W-1:0]   fsel_t;
    typedef logic [CR_W-1:0]    creg_t;
    typedef logic [TLUT_W-1:0]  tlut_t;

    typedef enum logic {
        OP_TERN = 1'b0,
        OP_BIN  = 1'b1
    } op_e;

    typedef struct packed {
        op_e    op;
        fsel_t  tgt;
        fsel_t  a;
        fsel_t  b;
        fsel_t  c;
        tlut_t  imm;
        field_t mask;
    } req_t;

    // Least-significant register bit position of field n.
    function automatic int field_lsb(input int n);
        return CR_W - FIELD_W * (n + 1);
    endfunction

    // Places a field-sized vector at the position of the selected field.
    function automatic creg_t place(input field_t v, input fsel_t sel);
        creg_t r;
        r = '0;
        for (int n = 0; n < NUM_FIELDS; n++) begin
            if (sel == fsel_t'(n)) begin
                r[field_lsb(n) +: FIELD_W] = v;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/cfl_field_mux.sv
module cfl_field_mux
    import cfl_pkg::*;
(
    input  creg_t  cr,
    input  fsel_t  sel,
    output field_t fld
);
    always_comb begin
        fld = '0;
        for (int n = 0; n < NUM_FIELDS; n++) begin
            if (sel == fsel_t'(n)) begin
                fld = cr[field_lsb(n) +: FIELD_W];
            end
        end
    end
endmodule

// File: rtl/cfl_lut_lane.sv
module cfl_lut_lane
    import cfl_pkg::*;
(
    input  op_e    op,
    input  logic   bit_a,
    input  logic   bit_b,
    input  logic   bit_c,
    input  tlut_t  imm,
    input  field_t dyn_lut,
    output logic   res
);
    logic [2:0] t_idx;
    logic [1:0] b_idx;

    always_comb begin
        t_idx = {bit_a, bit_b, bit_c};
        b_idx = {bit_a, bit_b};
        if (op == OP_TERN) begin
            res = imm[t_idx];
        end else begin
            res = dyn_lut[b_idx];
        end
    end
endmodule

// File: rtl/cfl_field_merge.sv
module cfl_field_merge
    import cfl_pkg::*;
(
    input  creg_t  cr,
    input  fsel_t  tgt,
    input  field_t new_bits,
    input  field_t mask,
    output creg_t  cr_next
);
    field_t merged;

    cfl_field_mux u_old (
        .cr  (cr),
        .sel (tgt),
        .fld (merged_old)
    );

    field_t merged_old;

    always_comb begin
        merged = (new_bits & mask) | (merged_old & ~mask);
    end

    for (genvar n = 0; n < NUM_FIELDS; n++) begin : g_field
        localparam int LSB = CR_W - FIELD_W * (n + 1);
        always_comb begin
            if (tgt == fsel_t'(n)) begin
                cr_next[LSB +: FIELD_W] = merged;
            end else begin
                cr_next[LSB +: FIELD_W] = cr[LSB +: FIELD_W];
            end
        end
    end
endmodule

// File: rtl/cfl_unit.sv
module cfl_unit
    import cfl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        op_sel,
    input  logic [31:0] cr_in,
    input  logic [2:0]  tgt_sel,
    input  logic [2:0]  src_a_sel,
    input  logic [2:0]  src_b_sel,
    input  logic [2:0]  src_c_sel,
    input  logic [7:0]  lut_imm,
    input  logic [3:0]  wr_mask,
    output logic        out_valid,
    output logic [31:0] cr_out
);
    req_t   req;
    field_t fa, fb, fc;
    field_t lane_res;
    creg_t  cr_next;

    always_comb begin
        req.op   = op_e'(op_sel);
        req.tgt  = tgt_sel;
        req.a    = src_a_sel;
        req.b    = src_b_sel;
        req.c    = src_c_sel;
        req.imm  = lut_imm;
        req.mask = wr_mask;
    end

    // All sources come from the incoming register (read before write).
    cfl_field_mux u_src_a (.cr(cr_in), .sel(req.a), .fld(fa));
    cfl_field_mux u_src_b (.cr(cr_in), .sel(req.b), .fld(fb));
    cfl_field_mux u_src_c (.cr(cr_in), .sel(req.c), .fld(fc));

    for (genvar k = 0; k < FIELD_W; k++) begin : g_lane
        cfl_lut_lane u_lane (
            .op      (req.op),
            .bit_a   (fa[k]),
            .bit_b   (fb[k]),
            .bit_c   (fc[k]),
            .imm     (req.imm),
            .dyn_lut (fc),
            .res     (lane_res[k])
        );
    end

    cfl_field_merge u_merge (
        .cr       (cr_in),
        .tgt      (req.tgt),
        .new_bits (lane_res),
        .mask     (req.mask),
        .cr_next  (cr_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            cr_out    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                cr_out <= cr_next;
            end
        end
    end
endmodule

// File: rtl/cfl_unit_chk.sv
module cfl_unit_chk
    import cfl_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] cr_in,
    input logic [2:0]  tgt_sel,
    input logic [3:0]  wr_mask,
    input logic        out_valid,
    input logic [31:0] cr_out
);
    p_start_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(cr_out)));

    p_reset_r8: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && cr_out == 32'h0));

    p_zero_mask_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && wr_mask == 4'h0) |=> (cr_out == $past(cr_in)));

    p_masked_only_r4: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (((cr_out ^ $past(cr_in))
                       & ~place($past(wr_mask), $past(tgt_sel))) == 32'h0));

    p_other_fields_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (((cr_out ^ $past(cr_in))
                       & ~place(4'hF, $past(tgt_sel))) == 32'h0));
endmodule

bind cfl_unit cfl_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .cr_in     (cr_in),
    .tgt_sel   (tgt_sel),
    .wr_mask   (wr_mask),
    .out_valid (out_valid),
    .cr_out    (cr_out)
);

// File: tb/cfl_unit_test.sv
module cfl_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        op_sel = 1'b0;
    logic [31:0] cr_in = '0;
    logic [2:0]  tgt_sel = '0, src_a_sel = '0, src_b_sel = '0, src_c_sel = '0;
    logic [7:0]  lut_imm = '0;
    logic [3:0]  wr_mask = '0;
    logic        out_valid;
    logic [31:0] cr_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfl_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .cr_in(cr_in), .tgt_sel(tgt_sel), .src_a_sel(src_a_sel),
        .src_b_sel(src_b_sel), .src_c_sel(src_c_sel), .lut_imm(lut_imm),
        .wr_mask(wr_mask), .out_valid(out_valid), .cr_out(cr_out)
    );

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        return s * 32'd1664525 + 32'd1013904223;
    endfunction

    function automatic logic [3:0] fld(input logic [31:0] cr, input int n);
        return 4'((cr >> (28 - 4*n)) & 32'hF);
    endfunction

    // Expected register computed from the requirement text.
    function automatic logic [31:0] model(input logic op, input int t, input int a,
                                          input int b, input int c, input logic [7:0] imm,
                                          input logic [3:0] m, input logic [31:0] cr);
        logic [3:0] fa, fb, fc;
        logic [31:0] r;
        int idx;
        fa = fld(cr, a); fb = fld(cr, b); fc = fld(cr, c);
        r = cr;
        for (int j = 0; j < 4; j++) begin
            logic v;
            if (!op) begin
                idx = 4*int'(fa[j]) + 2*int'(fb[j]) + int'(fc[j]);
                v = imm[idx];
            end else begin
                idx = 2*int'(fa[j]) + int'(fb[j]);
                v = fc[idx];
            end
            if (m[j]) r[28 - 4*t + j] = v;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One-cycle strobe; returns cr_out seen in the result cycle.
    task automatic run_op(input logic op, input int t, input int a, input int b,
                          input int c, input logic [7:0] imm, input logic [3:0] m,
                          input logic [31:0] cr, output logic [31:0] got);
        @(negedge clk);
        op_sel = op; tgt_sel = 3'(t); src_a_sel = 3'(a); src_b_sel = 3'(b);
        src_c_sel = 3'(c); lut_imm = imm; wr_mask = m; cr_in = cr;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid === 1'b1, "R7 valid", {31'b0, out_valid}, 32'h1);
        got = cr_out;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] got, exp, cr, got2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        check(out_valid === 1'b0, "R8 valid", {31'b0, out_valid}, 32'h0);
        check(cr_out === 32'h0, "R8 cr", cr_out, 32'h0);
        rst = 1'b0;

        // R1: imm F0 copies source A; field 0 copied into field 7
        cr = 32'hA000_0000;
        run_op(1'b0, 7, 0, 1, 2, 8'hF0, 4'hF, cr, got);
        check(got[3:0] === 4'hA, "R1 layout", got, 32'hA000_000A);
        check(got === 32'hA000_000A, "R1 full", got, 32'hA000_000A);

        // R4: single mask bit 3 writes only field bit 0 (cr bit 31-4n)
        run_op(1'b0, 2, 0, 0, 0, 8'hFF, 4'h8, 32'h0, got);
        check(got === 32'h0080_0000, "R4 mask bit", got, 32'h0080_0000);

        // R2 + R4: all immediates, all masks
        for (int imm = 0; imm < 256; imm++) begin
            for (int m = 0; m < 16; m++) begin
                int t, a, b, c;
                seed = next_rand(seed); cr = seed;
                t = (imm + m) % 8; a = imm % 8; b = (imm / 8) % 8; c = m % 8;
                exp = model(1'b0, t, a, b, c, 8'(imm), 4'(m), cr);
                run_op(1'b0, t, a, b, c, 8'(imm), 4'(m), cr, got);
                check(got === exp, (m == 0) ? "R4 zero mask" : "R2 ternary", got, exp);
            end
        end

        // R3 + R5 + R6: every selector combination, binary
        for (int t = 0; t < 8; t++) begin
            for (int a = 0; a < 8; a++) begin
                for (int b = 0; b < 8; b++) begin
                    for (int c = 0; c < 8; c++) begin
                        logic [3:0] m;
                        seed = next_rand(seed); cr = seed;
                        m = 4'(seed >> 7);
                        exp = model(1'b1, t, a, b, c, 8'h00, m, cr);
                        run_op(1'b1, t, a, b, c, 8'(seed >> 20), m, cr, got);
                        check(got === exp, (t == a || t == c) ? "R6 overlap" : "R3 binary",
                              got, exp);
                        check((got & ~(32'hF << (28 - 4*t))) === (cr & ~(32'hF << (28 - 4*t))),
                              "R5 others", got, cr);
                    end
                end
            end
        end

        // R6: ternary with target as all sources, imm 0x0F inverts
        run_op(1'b0, 3, 3, 3, 3, 8'h0F, 4'hF, 32'h0005_0000, got);
        check(got === 32'h000A_0000, "R6 self", got, 32'h000A_0000);

        // R9: binary result independent of immediate
        cr = 32'h1234_5678;
        run_op(1'b1, 1, 2, 3, 4, 8'h00, 4'hF, cr, got);
        run_op(1'b1, 1, 2, 3, 4, 8'hFF, 4'hF, cr, got2);
        check(got === got2, "R9 imm ignored", got2, got);

        // R7: hold without strobe
        @(negedge clk);
        cr_in = 32'hFFFF_FFFF; lut_imm = 8'h55;
        @(negedge clk);
        check(out_valid === 1'b0, "R7 idle", {31'b0, out_valid}, 32'h0);
        check(cr_out === got2, "R7 hold", cr_out, got2);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule